// File: doc/BRIEF.md
# ROM Shadow Remap Controller

This block lets the contents of a slow, narrow system ROM run out of fast wide RAM. After reset the real ROM answers in its normal window, and a shadow RAM of the same size answers in a companion window just below it. Software copies the ROM image into that companion window. It then writes once to a control location, and the two windows trade places. From that point, accesses to the ROM window land in the shadow RAM on the wide local path. The legacy bus never sees a strobe for them, and the shadow copy can no longer be written.

The swap comes from one mode bit that is XOR-ed into the address line just above the window size. The same bit also turns on write protection and local steering. A second write to the control location swaps the windows back. The mode bit changes only after the writing bus cycle has ended, so an access can never see the mapping change partway through.

Top module: `shadow_remap`

## Requirements
- R1: After reset the block is in load mode: an access to the ROM window (address bits [23:19] all ones by default) gives ramSel=0 and passes the strobe to legacyStrobe.
- R2: In load mode, an access to the companion window (the ROM window base with address bit 19 inverted) gives ramSel=1, ramAddr equal to the low 19 address bits, legacyStrobe=0, and ramWe=1 on a write (rnw=0).
- R3: Each strobed write (rnw=0) to the control address toggles the mode. The new mode applies from the first clock edge at which strobe is sampled low after that write, so a second such write restores the previous mode.
- R4: The mode does not change while the strobe of the control write is still high, even when the address moves into the ROM window during that cycle.
- R5: In run mode, an access to the ROM window gives ramSel=1, ramAddr equal to the low 19 address bits, localFlag=1 and legacyStrobe=0.
- R6: In run mode, a write to the ROM window still gives ramSel=1, but ramWe=0 and wrInhibit=1.
- R7: In run mode, an access to the companion window gives ramSel=0 and goes to the legacy bus (legacyStrobe=strobe).
- R8: A strobed read (rnw=1) of the control address leaves the mode unchanged.
- R9: While strobe is low, ramSel, ramWe, wrInhibit, localFlag and legacyStrobe are all 0.
- R10: An address outside both windows gives ramSel=0 and ramWe=0, and the strobe passes to legacyStrobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 24 | Bus address |
| rnw | input | 1 | 1 = read, 0 = write |
| strobe | input | 1 | Bus cycle strobe, active high |
| ramAddr | output | 19 | Offset into the shadow RAM |
| ramSel | output | 1 | Shadow RAM select |
| ramWe | output | 1 | Shadow RAM write enable |
| wrInhibit | output | 1 | Write aimed at the protected shadow was blocked |
| localFlag | output | 1 | Cycle is served on the wide local path |
| legacyStrobe | output | 1 | Strobe passed on to the legacy bus |

## Verification
The mode flip and the decode of the next access can fall on the same clock edge. This happens when the control write's strobe is low for only a single edge and a new access to the ROM window starts right after it. The bench drives exactly that back-to-back pattern. It expects the new access to be decoded with the new mapping (shadow selected, no legacy strobe), while an address change made earlier, with the strobe still held high, has to be decoded with the old mapping.

// File: rtl/shadow_remap_pkg.sv
package shadow_remap_pkg;
  // strobes passed from the mode control to the address datapath
  typedef struct packed {
    logic runMode;      // 1: windows swapped, shadow protected
    logic cycleActive;  // a bus cycle is in progress
  } ctrlStrobes_t;
endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_remap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hDFF000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rnw,
  input  logic              strobe,
  output ctrlStrobes_t      ctrlS
);
  logic runMode;
  logic strobeQ;
  logic pendQ;
  logic ctrlHit;

  assign ctrlHit = strobe && !rnw && (addr == CTRL_ADDR);

  // toggle is deferred to the edge that first sees the strobe low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runMode <= 1'b0;
      strobeQ <= 1'b0;
      pendQ   <= 1'b0;
    end else begin
      strobeQ <= strobe;
      if (ctrlHit) pendQ <= 1'b1;
      if (!strobe && strobeQ) begin
        if (pendQ) runMode <= ~runMode;
        pendQ <= 1'b0;
      end
    end
  end

  assign ctrlS.runMode     = runMode;
  assign ctrlS.cycleActive = strobe;
endmodule

// File: rtl/shadow_dp.sv
module shadow_dp
  import shadow_remap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WIN_LOG2 = 19,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hF80000
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rnw,
  input  ctrlStrobes_t        ctrlS,
  output logic [WIN_LOG2-1:0] ramAddr,
  output logic                ramSel,
  output logic                ramWe,
  output logic                wrInhibit,
  output logic                localFlag
);
  localparam logic [ADDR_W-1:0] SWAP_BIT   = ADDR_W'(1) << WIN_LOG2;
  localparam logic [ADDR_W-1:0] SHADOW_LOAD = ROM_BASE ^ SWAP_BIT;
  localparam int TAG_W = ADDR_W - WIN_LOG2;

  logic [ADDR_W-1:0] effAddr;
  logic              inShadow;
  logic              ramHit;

  always_comb begin
    effAddr   = addr ^ (ctrlS.runMode ? SWAP_BIT : '0);
    inShadow  = effAddr[ADDR_W-1 -: TAG_W] == SHADOW_LOAD[ADDR_W-1 -: TAG_W];
    ramHit    = ctrlS.cycleActive && inShadow;
    ramSel    = ramHit;
    ramAddr   = addr[WIN_LOG2-1:0];
    ramWe     = ramHit && !rnw && !ctrlS.runMode;
    wrInhibit = ramHit && !rnw && ctrlS.runMode;
    localFlag = ramHit;
  end
endmodule

// File: rtl/shadow_remap.sv
module shadow_remap
  import shadow_remap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WIN_LOG2 = 19,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hF80000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hDFF000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rnw,
  input  logic                strobe,
  output logic [WIN_LOG2-1:0] ramAddr,
  output logic                ramSel,
  output logic                ramWe,
  output logic                wrInhibit,
  output logic                localFlag,
  output logic                legacyStrobe
);
  ctrlStrobes_t ctrlS;
  logic         runMode;

  shadow_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rnw(rnw), .strobe(strobe), .ctrlS(ctrlS)
  );

  shadow_dp #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .ROM_BASE(ROM_BASE)) u_dp (
    .addr(addr), .rnw(rnw), .ctrlS(ctrlS), .ramAddr(ramAddr), .ramSel(ramSel),
    .ramWe(ramWe), .wrInhibit(wrInhibit), .localFlag(localFlag)
  );

  assign runMode      = ctrlS.runMode;
  assign legacyStrobe = strobe && !localFlag;
endmodule

// File: rtl/shadow_remap_chk.sv
module shadow_remap_chk (
  input logic clk,
  input logic rstN,
  input logic strobe,
  input logic rnw,
  input logic ramSel,
  input logic ramWe,
  input logic legacyStrobe,
  input logic runMode
);
  p_reset_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !runMode);

  p_no_midcycle_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe) && strobe) |-> $stable(runMode));

  p_steered_no_legacy_r5: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> !legacyStrobe);

  p_protect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && ramSel && !rnw) |-> !ramWe);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |-> (!ramSel && !ramWe && !legacyStrobe));
endmodule

bind shadow_remap shadow_remap_chk u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .rnw(rnw), .ramSel(ramSel),
  .ramWe(ramWe), .legacyStrobe(legacyStrobe), .runMode(runMode)
);

// File: tb/shadow_remap_tb.sv
module shadow_remap_tb;
  localparam int CLK_P = 10;
  localparam logic [23:0] ROM_A  = 24'hF81234;
  localparam logic [23:0] ROM_TOP = 24'hFFFFFC;
  localparam logic [23:0] SHD_A  = 24'hF01234;
  localparam logic [23:0] CTRL_A = 24'hDFF000;
  localparam logic [23:0] OTH_A  = 24'h200000;

  logic clk = 0, rstN = 0;
  logic [23:0] addr = '0;
  logic rnw = 1, strobe = 0;
  logic [18:0] ramAddr;
  logic ramSel, ramWe, wrInhibit, localFlag, legacyStrobe;
  int checks = 0, errors = 0;

  shadow_remap u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rnw(rnw), .strobe(strobe),
    .ramAddr(ramAddr), .ramSel(ramSel), .ramWe(ramWe), .wrInhibit(wrInhibit),
    .localFlag(localFlag), .legacyStrobe(legacyStrobe)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start an access just after an edge; outputs are combinational
  task automatic startAcc(input logic [23:0] a, input logic r);
    addr = a; rnw = r; strobe = 1; #1;
  endtask

  // finish the cycle: strobe sampled low at one edge, then next slot
  task automatic endAcc();
    @(posedge clk); #1 strobe = 0; rnw = 1;
    @(posedge clk); #1;
  endtask

  task automatic testReset();
    startAcc(ROM_A, 1);
    chk("R1 ramSel", ramSel, 0);
    chk("R1 legacyStrobe", legacyStrobe, 1);
    endAcc();
  endtask

  task automatic testLoadShadow();
    startAcc(SHD_A, 0);
    chk("R2 ramSel", ramSel, 1);
    chk("R2 ramAddr", ramAddr, 19'h01234);
    chk("R2 ramWe", ramWe, 1);
    chk("R2 legacyStrobe", legacyStrobe, 0);
    endAcc();
  endtask

  task automatic testToggleOn();
    startAcc(CTRL_A, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    addr = ROM_A; rnw = 1; #1;
    chk("R4 ramSel mid-cycle", ramSel, 0);
    @(posedge clk); #1 strobe = 0;
    @(posedge clk); #1;
    startAcc(ROM_A, 1);  // back-to-back with the flip
    chk("R3 ramSel after toggle", ramSel, 1);
    chk("R5 ramAddr", ramAddr, 19'h01234);
    chk("R5 localFlag", localFlag, 1);
    chk("R5 legacyStrobe", legacyStrobe, 0);
    endAcc();
  endtask

  task automatic testProtect();
    startAcc(ROM_TOP, 0);
    chk("R6 ramSel", ramSel, 1);
    chk("R6 ramWe", ramWe, 0);
    chk("R6 wrInhibit", wrInhibit, 1);
    endAcc();
  endtask

  task automatic testRunShadowAddr();
    startAcc(SHD_A, 0);
    chk("R7 ramSel", ramSel, 0);
    chk("R7 legacyStrobe", legacyStrobe, 1);
    endAcc();
  endtask

  task automatic testCtrlRead();
    startAcc(CTRL_A, 1);
    endAcc();
    startAcc(ROM_A, 1);
    chk("R8 ramSel still run", ramSel, 1);
    endAcc();
  endtask

  task automatic testIdle();
    addr = ROM_A; rnw = 0; strobe = 0; #1;
    chk("R9 ramSel", ramSel, 0);
    chk("R9 ramWe", ramWe, 0);
    chk("R9 wrInhibit", wrInhibit, 0);
    chk("R9 localFlag", localFlag, 0);
    chk("R9 legacyStrobe", legacyStrobe, 0);
    rnw = 1;
    @(posedge clk); #1;
  endtask

  task automatic testOther();
    startAcc(OTH_A, 0);
    chk("R10 ramSel", ramSel, 0);
    chk("R10 ramWe", ramWe, 0);
    chk("R10 legacyStrobe", legacyStrobe, 1);
    endAcc();
  endtask

  task automatic testToggleOff();
    startAcc(CTRL_A, 0);
    endAcc();
    startAcc(ROM_A, 1);
    chk("R3 ramSel after second toggle", ramSel, 0);
    chk("R3 legacyStrobe", legacyStrobe, 1);
    endAcc();
    startAcc(SHD_A, 1);
    chk("R3 shadow back at load address", ramSel, 1);
    endAcc();
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;
    testReset();
    testLoadShadow();
    testToggleOn();
    testProtect();
    testRunShadowAddr();
    testCtrlRead();
    testIdle();
    testOther();
    testToggleOff();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule